// File: doc/BRIEF.md
# Port Direction and Pulldown Control

This block is the register side of a small microcontroller's parallel I/O. It stores the direction of each port A pin and a write-only bank of pulldown inhibit bits. From these it produces an output-enable line and a pulldown-enable line for every port A pin, and a pulldown-enable line for every port C pin. Port C's direction bits are held elsewhere and come in as an input. Port C pulldowns are controlled in groups of four pins, with one inhibit bit per group.

Software reaches the two registers over a simple bus: an address, a write strobe, write data and read data. Writes take effect on the rising clock edge. Reads are combinational. A pulldown is active only when three things are true: the global pulldown option input is set, the pin is an input, and its inhibit bit is clear. Reset makes every port A pin an input with its pulldown on.

Top module: `gpio_pull_port`

## Requirements
- R1: When the write strobe is high and the address is 0x04, write data bits [5:0] are loaded into the direction register on the rising edge. From that edge on, `paOutEn[i]` equals the direction bit for pin i: 1 means output, 0 means input.
- R2: A read at address 0x04 returns the direction register in bits [5:0], and bits [7:6] always read as 0.
- R3: Reset clears the direction register and every inhibit bit. After reset, `paOutEn` is 0, and every pulldown enable is 1 for each port C pin whose `pcDir` bit is 0, provided `swPullEn` is 1.
- R4: When the write strobe is high and the address is 0x10, all eight write data bits are loaded into the inhibit register. A read at 0x10 always returns the fixed value 0x00, whatever the register holds.
- R5: `paPullEn[i]` is 1 exactly when `swPullEn` is 1, the direction bit for pin i is 0, and inhibit bit i (bits [5:0]) is 0. A pin set as an output therefore never has its pulldown on.
- R6: Inhibit bit 6 governs port C pins 0 to 3, and inhibit bit 7 governs pins 4 to 7. `pcPullEn[p]` is 1 exactly when `swPullEn` is 1, `pcDir[p]` is 0, and the group's inhibit bit is 0.
- R7: While `swPullEn` is 0, every bit of `paPullEn` and `pcPullEn` is 0.
- R8: A cycle with the write strobe low, or with a write to any address other than 0x04 or 0x10, changes neither register.
- R9: A read at any address other than 0x04 or 0x10 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| pcDir | input | 8 | Port C direction bits (1 = output) |
| swPullEn | input | 1 | Global pulldown option (1 = pulldowns allowed) |
| paOutEn | output | 6 | Port A output-buffer enables |
| paPullEn | output | 6 | Port A pulldown enables |
| pcPullEn | output | 8 | Port C pulldown enables |

## Verification
The bench sets pins as outputs while their inhibit bits are clear. A design that forgot the direction term would leave a pulldown fighting an output driver. It writes a different value to each half of the port C pair, so swapping the nibble mapping shows up as the wrong group of four pins losing its pulldown. Reading the inhibit register after writing it exposes a design that echoes the stored bits instead of the fixed pattern. Writing to a neighbouring address, and strobing with the write line low, catches loose address decoding that would corrupt the direction register.

// File: rtl/gpio_pull_pkg.sv
package gpio_pull_pkg;
  // Strobes from the bus decoder to the register datapath.
  typedef struct packed {
    logic dirWr;
    logic pullWr;
    logic dirRd;
    logic pullRd;
  } regStrobeT;
endpackage

// File: rtl/gpio_pull_ctrl.sv
module gpio_pull_ctrl
  import gpio_pull_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DIR_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] PULL_OFS = 8'h10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobeT         strobe
);
  logic hitDir;
  logic hitPull;

  always_comb begin
    hitDir        = (busAddr == DIR_OFS);
    hitPull       = (busAddr == PULL_OFS);
    strobe.dirRd  = hitDir;
    strobe.pullRd = hitPull;
    strobe.dirWr  = hitDir && busWe;
    strobe.pullWr = hitPull && busWe;
  end
endmodule

// File: rtl/gpio_pull_dp.sv
module gpio_pull_dp
  import gpio_pull_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PA_PINS = 6,
  parameter int PC_PINS = 8,
  parameter int PC_GROUP = 4,
  parameter logic [DATA_W-1:0] WO_READ_VAL = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobeT          strobe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [PC_PINS-1:0] pcDir,
  input  logic               swPullEn,
  output logic [PA_PINS-1:0] paOutEn,
  output logic [PA_PINS-1:0] paPullEn,
  output logic [PC_PINS-1:0] pcPullEn
);
  localparam int PC_GROUPS = PC_PINS / PC_GROUP;
  localparam int INH_W = PA_PINS + PC_GROUPS;

  logic [PA_PINS-1:0] dirReg;
  logic [INH_W-1:0]   inhReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
    end else if (strobe.dirWr) begin
      dirReg <= busWdata[PA_PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inhReg <= '0;
    end else if (strobe.pullWr) begin
      inhReg <= busWdata[INH_W-1:0];
    end
  end

  always_comb begin
    if (strobe.dirRd) begin
      busRdata = DATA_W'(dirReg);
    end else if (strobe.pullRd) begin
      busRdata = WO_READ_VAL;
    end else begin
      busRdata = '0;
    end
  end

  assign paOutEn = dirReg;

  for (genvar i = 0; i < PA_PINS; i++) begin : g_paPull
    assign paPullEn[i] = swPullEn & ~dirReg[i] & ~inhReg[i];
  end

  for (genvar p = 0; p < PC_PINS; p++) begin : g_pcPull
    localparam int GRP = p / PC_GROUP;
    assign pcPullEn[p] = swPullEn & ~pcDir[p] & ~inhReg[PA_PINS + GRP];
  end
endmodule

// File: rtl/gpio_pull_port.sv
module gpio_pull_port
  import gpio_pull_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PA_PINS = 6,
  parameter int PC_PINS = 8,
  parameter int PC_GROUP = 4,
  parameter logic [ADDR_W-1:0] DIR_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] PULL_OFS = 8'h10,
  parameter logic [DATA_W-1:0] WO_READ_VAL = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [PC_PINS-1:0] pcDir,
  input  logic               swPullEn,
  output logic [PA_PINS-1:0] paOutEn,
  output logic [PA_PINS-1:0] paPullEn,
  output logic [PC_PINS-1:0] pcPullEn
);
  regStrobeT strobe;

  gpio_pull_ctrl #(
    .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS), .PULL_OFS(PULL_OFS)
  ) ctrl_i (
    .busAddr(busAddr), .busWe(busWe), .strobe(strobe)
  );

  gpio_pull_dp #(
    .DATA_W(DATA_W), .PA_PINS(PA_PINS), .PC_PINS(PC_PINS),
    .PC_GROUP(PC_GROUP), .WO_READ_VAL(WO_READ_VAL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .pcDir(pcDir), .swPullEn(swPullEn),
    .paOutEn(paOutEn), .paPullEn(paPullEn), .pcPullEn(pcPullEn)
  );
endmodule

// File: rtl/gpio_pull_port_chk.sv
module gpio_pull_port_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PA_PINS = 6,
  parameter int PC_PINS = 8,
  parameter logic [ADDR_W-1:0] DIR_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] PULL_OFS = 8'h10,
  parameter logic [DATA_W-1:0] WO_READ_VAL = '0
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [PC_PINS-1:0] pcDir,
  input logic               swPullEn,
  input logic [PA_PINS-1:0] paOutEn,
  input logic [PA_PINS-1:0] paPullEn,
  input logic [PC_PINS-1:0] pcPullEn
);
  a_r1_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == DIR_OFS) |=> (paOutEn == $past(busWdata[PA_PINS-1:0])));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == DIR_OFS) |-> (busRdata[DATA_W-1:PA_PINS] == '0));

  a_r4_wo_read: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == PULL_OFS) |-> (busRdata == WO_READ_VAL));

  a_r5_out_no_pull: assert property (@(posedge clk) disable iff (!rstN)
    ((paPullEn & paOutEn) == '0));

  a_r6_pc_out_no_pull: assert property (@(posedge clk) disable iff (!rstN)
    ((pcPullEn & pcDir) == '0));

  a_r7_global_off: assert property (@(posedge clk) disable iff (!rstN)
    !swPullEn |-> (paPullEn == '0 && pcPullEn == '0));

  a_r8_no_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busWe || busAddr != DIR_OFS) |=> $stable(paOutEn));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != DIR_OFS && busAddr != PULL_OFS) |-> (busRdata == '0));
endmodule

bind gpio_pull_port gpio_pull_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PA_PINS(PA_PINS), .PC_PINS(PC_PINS),
  .DIR_OFS(DIR_OFS), .PULL_OFS(PULL_OFS), .WO_READ_VAL(WO_READ_VAL)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .pcDir(pcDir),
  .swPullEn(swPullEn), .paOutEn(paOutEn), .paPullEn(paPullEn),
  .pcPullEn(pcPullEn)
);

// File: tb/gpio_pull_port_tb_top.sv
module gpio_pull_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [7:0] pcDir = 8'h00;
  logic       swPullEn = 1'b1;
  logic [5:0] paOutEn;
  logic [5:0] paPullEn;
  logic [7:0] pcPullEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [7:0] rdata;
    logic [5:0] outEn;
    logic [5:0] paPull;
    logic [7:0] pcPull;
  } expT;

  expT q[$];

  // Reference state kept from the requirements
  logic [5:0] mDir = '0;
  logic [7:0] mInh = '0;

  always #4 clk = ~clk;

  gpio_pull_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pcDir(pcDir),
    .swPullEn(swPullEn), .paOutEn(paOutEn), .paPullEn(paPullEn),
    .pcPullEn(pcPullEn)
  );

  function automatic expT predict(string tag);
    expT e;
    e.tag = tag;
    if (busAddr == 8'h04) e.rdata = {2'b00, mDir};
    else e.rdata = 8'h00;
    e.outEn = mDir;
    for (int i = 0; i < 6; i++) e.paPull[i] = swPullEn & ~mDir[i] & ~mInh[i];
    for (int p = 0; p < 8; p++) e.pcPull[p] = swPullEn & ~pcDir[p] & ~mInh[6 + p / 4];
    return e;
  endfunction

  task automatic step(string tag, logic [7:0] a, logic we, logic [7:0] d,
                      logic [7:0] pcd, logic sw);
    @(negedge clk);
    busAddr = a; busWe = we; busWdata = d; pcDir = pcd; swPullEn = sw;
    @(posedge clk);
    if (we && a == 8'h04) mDir = d[5:0];
    if (we && a == 8'h10) mInh = d;
    #1;
    q.push_back(predict(tag));
  endtask

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops each expected item in the cycle it was produced
  always @(posedge clk) begin
    #2;
    while (q.size() > 0) begin
      expT e;
      e = q.pop_front();
      cmp(e.tag, "rdata", busRdata, e.rdata);
      cmp(e.tag, "paOutEn", {2'b00, paOutEn}, {2'b00, e.outEn});
      cmp(e.tag, "paPullEn", {2'b00, paPullEn}, {2'b00, e.paPull});
      cmp(e.tag, "pcPullEn", pcPullEn, e.pcPull);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    // R3 reset state, read at direction offset (R2)
    step("R3_reset", 8'h04, 0, 8'h00, 8'h00, 1);
    // R1 + R2: write all ones, upper bits read 0
    step("R1_R2_dir_all", 8'h04, 1, 8'hFF, 8'h00, 1);
    // R5: outputs lose pulldown even with inhibit clear
    step("R5_out_pull", 8'h04, 1, 8'h15, 8'h00, 1);
    // R4: write inhibit, read back fixed 0x00
    step("R4_inh_wr", 8'h10, 1, 8'h0A, 8'h00, 1);
    step("R4_inh_rd", 8'h10, 0, 8'hFF, 8'h00, 1);
    // R6: upper group inhibited only
    step("R6_upper", 8'h10, 1, 8'h80, 8'h00, 1);
    // R6: lower group inhibited only, some port C outputs
    step("R6_lower", 8'h10, 1, 8'h40, 8'h30, 1);
    step("R6_pcdir", 8'h00, 0, 8'h00, 8'hC3, 1);
    // R7: global disable
    step("R7_global_off", 8'h04, 0, 8'h00, 8'h00, 0);
    step("R7_back_on", 8'h04, 1, 8'h00, 8'h00, 1);
    // R8: neighbour address and strobe low
    step("R8_neighbour", 8'h05, 1, 8'h3F, 8'h00, 1);
    step("R8_nostrobe", 8'h04, 0, 8'h2A, 8'h00, 1);
    step("R8_nostrobe_inh", 8'h10, 0, 8'hFF, 8'h00, 1);
    step("R8_neighbour_inh", 8'h11, 1, 8'hFF, 8'h00, 1);
    // R9: unmapped reads
    step("R9_unmapped", 8'h20, 0, 8'h00, 8'h00, 1);
    step("R9_unmapped_ff", 8'hFF, 0, 8'h00, 8'h00, 1);
    // R5: mixed direction and inhibit
    step("R5_mix_inh", 8'h10, 1, 8'h23, 8'h0F, 1);
    step("R5_mix_dir", 8'h04, 1, 8'h0C, 8'h0F, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule